// File: doc/BRIEF.md
# Packed Bitmap to Planar Tile Converter

This block sits in the byte path that carries graphics toward video memory. The bytes coming in are a packed-pixel bitmap: each pixel's colour index sits in contiguous bits of a byte. The bytes going out are 8x8 character tiles in bitplane form, where each output byte holds one bit of colour for the eight pixels of one tile row. A small control field chooses the colour depth (2, 4 or 8 bits per pixel) and how many characters lie side by side in one bitmap row.

The block works on one band at a time. A band is eight pixel rows of the bitmap, the full width of the row. It accepts a whole band through a valid/ready input, scattering each byte's bits into an internal tile buffer as it arrives. It then drains the buffer in tile order through a valid/ready output. The number of bytes out equals the number of bytes in. The control field is captured with the first byte of each band.

Top module: `planar_tile_conv`

## Requirements
- R1: After reset is released, `in_ready` is 1 and `out_valid` is 0.
- R2: Control bits 1:0 pick the depth D: value 0 gives 8 bits per pixel, value 1 gives 4, and both 2 and 3 give 2.
- R3: Control bits 4:2 hold a value F, and a band is N = 2^min(F, CPR_LOG2_MAX) characters wide. With the default CPR_LOG2_MAX of 2, a field of 7 acts as 2 (four characters).
- R4: A band takes exactly 8·D·N input bytes and then yields exactly 8·D·N output bytes. After the last output byte is taken, the block accepts input again.
- R5: At 2 bpp, the plane q (0 or 1) byte of row l of a character is at offset 2l+q inside that character's 16 output bytes.
- R6: At 4 bpp, the plane q (0..3) byte of row l is at offset 16·(q/2) + 2l + (q mod 2) inside the character's 32 bytes.
- R7: At 8 bpp, the plane q (0..7) byte of row l is at offset 16·(q/2) + 2l + (q mod 2) inside the character's 64 bytes.
- R8: Pixel p (0..7, left to right) of a tile row is read from input byte p/(8/D) of that row of that character, at bits (p mod (8/D))·D and up. Bit q of that pixel goes to bit 7−p of the plane q byte, so the leftmost pixel lands in the MSB.
- R9: Input bytes come row by row: input index = l·D·N + c·D + b, where b is the byte within the character's row. Character c occupies output bytes c·8D up to c·8D+8D−1.
- R10: `in_ready` and `out_valid` are never 1 in the same cycle. While a band drains, no input byte is taken.
- R11: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` holds its value into the next cycle.
- R12: The control field is sampled when the first byte of a band is accepted. Changes to it later in the same band have no effect on that band.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctrl_i | input | 5 | Bits 1:0 depth select, bits 4:2 log2 of characters per row |
| in_valid | input | 1 | Input byte is valid |
| in_ready | output | 1 | Block accepts an input byte |
| in_data | input | 8 | Packed bitmap byte |
| out_valid | output | 1 | Output byte is valid |
| out_ready | input | 1 | Consumer takes the output byte |
| out_data | output | 8 | Planar tile byte |

## Verification
The assertions assume that the bytes of a band arrive only as whole bands. They also assume that `ctrl_i` holds a legal field whenever a band starts, and that reset is applied before any traffic. The stimulus always sends complete bands, and it sets the control field before the first byte of each band. In one band it changes the field right after the first byte is accepted, to show the captured value wins. Output back-pressure runs in three patterns: always ready, ready two cycles out of three, and ready one cycle in five. This stresses the hold behaviour without ever leaving a band unfinished.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

  typedef enum logic {
    PH_FILL  = 1'b0,
    PH_DRAIN = 1'b1
  } ptc_phase_e;

  // log2 of bits per pixel for a depth select code
  function automatic logic [1:0] depth_log2(input logic [1:0] sel);
    case (sel)
      2'd0:    return 2'd3;
      2'd1:    return 2'd2;
      default: return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/ptc_cfg_decode.sv
module ptc_cfg_decode #(
  parameter int unsigned CPR_LOG2_MAX = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] ctrl_i,
  input  logic       capture_i,
  input  logic       use_live_i,
  output logic [1:0] dl_o,
  output logic [2:0] cl_o
);
  import ptc_pkg::*;

  localparam logic [2:0] CL_CAP = 3'(CPR_LOG2_MAX);

  logic [4:0] cfg_q, cfg_d;
  logic [4:0] act;

  always_comb begin
    cfg_d = cfg_q;
    if (capture_i) cfg_d = ctrl_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= 5'd0;
    else        cfg_q <= cfg_d;
  end

  assign act  = use_live_i ? ctrl_i : cfg_q;
  assign dl_o = depth_log2(act[1:0]);
  assign cl_o = (act[4:2] > CL_CAP) ? CL_CAP : act[4:2];

endmodule

// File: rtl/ptc_fill_index.sv
module ptc_fill_index #(
  parameter int unsigned CPR_LOG2_MAX = 2,
  localparam int unsigned CW = (CPR_LOG2_MAX > 0) ? CPR_LOG2_MAX : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  input  logic [1:0]    dl_i,
  input  logic [2:0]    cl_i,
  output logic [2:0]    row_o,
  output logic [CW-1:0] chr_o,
  output logic [2:0]    byt_o,
  output logic          at_start_o,
  output logic          at_end_o
);

  logic [2:0]    row_q, row_d;
  logic [CW-1:0] chr_q, chr_d;
  logic [2:0]    byt_q, byt_d;
  logic [2:0]    byt_max;
  logic [CW:0]   chr_lim;
  logic          byt_last, chr_last;

  assign byt_max  = 3'((4'd1 << dl_i) - 4'd1);
  assign chr_lim  = (CW+1)'(1) << cl_i;
  assign byt_last = (byt_q == byt_max);
  assign chr_last = ({1'b0, chr_q} == chr_lim - (CW+1)'(1));

  always_comb begin
    row_d = row_q;
    chr_d = chr_q;
    byt_d = byt_q;
    if (step_i) begin
      if (byt_last) begin
        byt_d = 3'd0;
        if (chr_last) begin
          chr_d = '0;
          row_d = row_q + 3'd1;
        end else begin
          chr_d = chr_q + CW'(1);
        end
      end else begin
        byt_d = byt_q + 3'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= 3'd0;
      chr_q <= '0;
      byt_q <= 3'd0;
    end else begin
      row_q <= row_d;
      chr_q <= chr_d;
      byt_q <= byt_d;
    end
  end

  assign row_o      = row_q;
  assign chr_o      = chr_q;
  assign byt_o      = byt_q;
  assign at_start_o = (row_q == 3'd0) && (chr_q == '0) && (byt_q == 3'd0);
  assign at_end_o   = byt_last && chr_last && (row_q == 3'd7);

  // byte-in-row counter never reaches the depth in bytes
  assert_byte_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byt_q <= byt_max);

  // character counter stays below the characters per row
  assert_char_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, chr_q} < chr_lim);

endmodule

// File: rtl/ptc_tile_store.sv
module ptc_tile_store #(
  parameter int unsigned CPR_LOG2_MAX = 2,
  localparam int unsigned CW    = (CPR_LOG2_MAX > 0) ? CPR_LOG2_MAX : 1,
  localparam int unsigned DEPTH = 64 << CPR_LOG2_MAX,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [2:0]    row_i,
  input  logic [CW-1:0] chr_i,
  input  logic [2:0]    byt_i,
  input  logic [1:0]    dl_i,
  input  logic [7:0]    din_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    dout_o
);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] widx [8];
  logic [2:0]    wbit [8];
  logic [2:0]    pmask;
  logic [AW-1:0] chr_base;

  assign pmask    = 3'((4'd1 << dl_i) - 4'd1);
  assign chr_base = AW'(AW'(chr_i) << (3'd3 + 3'(dl_i)));

  // one lane per input bit: find its plane byte and bit slot
  for (genvar k = 0; k < 8; k++) begin : g_lane
    logic [2:0] pln;
    logic [2:0] pix;
    assign pln     = 3'(k) & pmask;
    assign pix     = (byt_i << (2'd3 - dl_i)) | (3'(k) >> dl_i);
    assign widx[k] = chr_base + AW'({pln[2:1], row_i, pln[0]});
    assign wbit[k] = ~pix;
  end

  always_ff @(posedge clk) begin
    if (we_i) begin
      for (int k = 0; k < 8; k++) begin
        mem[widx[k]][wbit[k]] <= din_i[k];
      end
    end
  end

  assign dout_o = mem[raddr_i];

endmodule

// File: rtl/planar_tile_conv.sv
module planar_tile_conv #(
  parameter int unsigned CPR_LOG2_MAX = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] ctrl_i,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data
);
  import ptc_pkg::*;

  localparam int unsigned CW    = (CPR_LOG2_MAX > 0) ? CPR_LOG2_MAX : 1;
  localparam int unsigned DEPTH = 64 << CPR_LOG2_MAX;
  localparam int unsigned AW    = $clog2(DEPTH);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  ptc_phase_e    phase_q, phase_d;
  logic [AW-1:0] rd_q, rd_d;
  logic [1:0]    dl;
  logic [2:0]    cl;
  logic [2:0]    row;
  logic [CW-1:0] chr;
  logic [2:0]    byt;
  logic          at_start, at_end;
  logic          accept, pop, rd_last;
  logic [AW:0]   band_sz;

  assign in_ready  = (phase_q == PH_FILL) && rst_s_n;
  assign out_valid = (phase_q == PH_DRAIN);
  assign accept    = in_valid && in_ready;
  assign pop       = out_valid && out_ready;

  ptc_cfg_decode #(.CPR_LOG2_MAX(CPR_LOG2_MAX)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .ctrl_i     (ctrl_i),
    .capture_i  (accept && at_start),
    .use_live_i ((phase_q == PH_FILL) && at_start),
    .dl_o       (dl),
    .cl_o       (cl)
  );

  ptc_fill_index #(.CPR_LOG2_MAX(CPR_LOG2_MAX)) u_idx (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .step_i     (accept),
    .dl_i       (dl),
    .cl_i       (cl),
    .row_o      (row),
    .chr_o      (chr),
    .byt_o      (byt),
    .at_start_o (at_start),
    .at_end_o   (at_end)
  );

  ptc_tile_store #(.CPR_LOG2_MAX(CPR_LOG2_MAX)) u_store (
    .clk     (clk),
    .we_i    (accept),
    .row_i   (row),
    .chr_i   (chr),
    .byt_i   (byt),
    .dl_i    (dl),
    .din_i   (in_data),
    .raddr_i (rd_q),
    .dout_o  (out_data)
  );

  assign band_sz = (AW+1)'(1) << (4'd3 + 4'(dl) + 4'(cl));
  assign rd_last = ({1'b0, rd_q} == band_sz - (AW+1)'(1));

  always_comb begin
    phase_d = phase_q;
    rd_d    = rd_q;
    case (phase_q)
      PH_FILL: begin
        if (accept && at_end) phase_d = PH_DRAIN;
      end
      PH_DRAIN: begin
        if (pop) begin
          if (rd_last) begin
            phase_d = PH_FILL;
            rd_d    = '0;
          end else begin
            rd_d = rd_q + AW'(1);
          end
        end
      end
      default: phase_d = PH_FILL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      phase_q <= PH_FILL;
      rd_q    <= '0;
    end else begin
      phase_q <= phase_d;
      rd_q    <= rd_d;
    end
  end

  // last input byte of a band hands over to draining
  assert_fill_handover_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (accept && at_end) |=> (out_valid && !in_ready));

  // last output byte returns to accepting input
  assert_drain_handover_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (pop && rd_last) |=> (in_ready && !out_valid));

  // phases never overlap
  assert_phase_excl_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    out_valid |-> !in_ready);

  // back-pressure holds the offered byte
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_s_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // decoded setup frozen once a band has started
  assert_cfg_frozen_R12: assert property (@(posedge clk) disable iff (!rst_s_n)
    (in_ready && !at_start) |-> ($stable(dl) && $stable(cl)));

endmodule

// File: tb/sim_planar_tile_conv.sv
module sim_planar_tile_conv;

  localparam int MAXL = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] ctrl_i;
  logic       in_valid;
  logic       in_ready;
  logic [7:0] in_data;
  logic       out_valid;
  logic       out_ready;
  logic [7:0] out_data;

  always #10 clk = ~clk;

  planar_tile_conv #(.CPR_LOG2_MAX(MAXL)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_i    (ctrl_i),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  int         checks = 0;
  int         errors = 0;
  int         sent = 0;
  int         got = 0;
  int         tick = 0;
  int         ready_mode = 0;
  bit         started = 0;
  bit         finished = 0;
  logic [7:0] stim [256];
  logic [7:0] exp_q [$];
  string      tag_q [$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int depth_of(input logic [1:0] sel);
    if (sel == 2'd0) return 8;
    if (sel == 2'd1) return 4;
    return 2;
  endfunction

  function automatic int chars_of(input logic [2:0] f);
    return 1 << ((int'(f) > MAXL) ? MAXL : int'(f));
  endfunction

  // gather form of the requirement: output byte o from the stimulus band
  function automatic logic [7:0] model(input int o, input int d, input int n);
    int c = o / (8 * d);
    int w = o % (8 * d);
    int q = 2 * (w / 16) + (w % 2);
    int l = (w % 16) / 2;
    int ppb = 8 / d;
    logic [7:0] r = 8'h00;
    for (int p = 0; p < 8; p++) begin
      int idx = l * d * n + c * d + p / ppb;
      r[7-p] = stim[idx][(p % ppb) * d + q];
    end
    return r;
  endfunction

  task automatic send(input logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    forever begin
      if (in_ready) begin
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_data  = 8'h00;
    sent++;
  endtask

  task automatic drain_and_check_turn();
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    check(in_ready == 1'b1, "R4 input reopened", in_ready, 1);
    check(out_valid == 1'b0, "R4 drain ended", out_valid, 0);
  endtask

  task automatic run_band(input logic [4:0] cfg, input logic [4:0] alt, input int seed,
                          input string tag);
    int d = depth_of(cfg[1:0]);
    int n = chars_of(cfg[4:2]);
    int total = 8 * d * n;
    for (int i = 0; i < total; i++) stim[i] = 8'((i * 73 + seed * 29) ^ (i >> 3) ^ seed);
    for (int o = 0; o < total; o++) begin
      exp_q.push_back(model(o, d, n));
      tag_q.push_back(tag);
    end
    ctrl_i = cfg;
    for (int i = 0; i < total; i++) begin
      send(stim[i]);
      if (i == 0) ctrl_i = alt;
    end
    drain_and_check_turn();
  endtask

  // hand-worked 2 bpp band: pixels 3,2,1,0 at the left of row 0
  task automatic run_directed();
    for (int o = 0; o < 16; o++) begin
      exp_q.push_back((o == 0) ? 8'hA0 : (o == 1) ? 8'hC0 : 8'h00);
      tag_q.push_back("R8 directed");
    end
    ctrl_i = 5'h02;
    for (int i = 0; i < 16; i++) send((i == 0) ? 8'h1B : 8'h00);
    drain_and_check_turn();
  endtask

  // scoreboard monitor
  logic [7:0] held;
  bit         held_v = 0;
  initial begin
    logic [7:0] e;
    string      t;
    out_ready = 1'b0;
    wait (started);
    forever begin
      @(negedge clk);
      tick++;
      if (held_v && out_valid) check(out_data == held, "R11 hold", out_data, held);
      if (held_v) check(out_valid == 1'b1, "R11 valid held", out_valid, 1);
      case (ready_mode)
        0:       out_ready = 1'b1;
        1:       out_ready = (tick % 3) != 0;
        default: out_ready = (tick % 5) == 0;
      endcase
      if (out_valid) check(in_ready == 1'b0, "R10", in_ready, 0);
      if (out_valid && out_ready) begin
        got++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 extra output", out_data, 0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_data == e, t, out_data, e);
        end
      end
      held_v = out_valid && !out_ready;
      held   = out_data;
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R4 watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    ctrl_i   = 5'h00;
    in_valid = 1'b0;
    in_data  = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    started = 1;

    ready_mode = 0; run_band(5'h02, 5'h02, 1, "R5 R8");
    run_directed();
    ready_mode = 1; run_band(5'h05, 5'h05, 2, "R6 R9");
    ready_mode = 2; run_band(5'h00, 5'h00, 3, "R7 R8");
    ready_mode = 1; run_band(5'h08, 5'h08, 4, "R7 R9");
    ready_mode = 0; run_band(5'h0B, 5'h0B, 5, "R2 R5");
    run_band(5'h1E, 5'h1E, 6, "R3 clamp");
    ready_mode = 1; run_band(5'h05, 5'h00, 7, "R12");
    ready_mode = 2; run_band(5'h0D, 5'h0D, 8, "R3 R6");

    check(got == sent, "R4 byte totals", got, sent);
    check(exp_q.size() == 0, "R4 queue empty", exp_q.size(), 0);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule